// File: doc/BRIEF.md
# Two-Operand NaN Propagation Selector

This block decides the outcome of a floating-point operation in which at least one of the two 80-bit extended operands carries a NaN class tag. Each operand arrives as a sign, a 15-bit biased exponent and a 64-bit significand whose top bit is the explicit integer bit. Each operand also comes with a NaN class flag from an upstream classifier. The block also receives the invalid-operation mask bit and a caller-supplied default NaN. From these it produces the value for the destination register, a destination write-enable, and an invalid-operation request. The request carries a flag that says whether the request is unmasked.

When both operands are NaNs, the one with the larger significand wins, whatever the operand order. Equal significands select the supplied default NaN. A quiet NaN passes through silently. A signalling NaN is either quieted and written (invalid masked) or blocks the write (invalid unmasked). In both cases it raises invalid. Encodings that carry the NaN tag but have a clear integer bit are unsupported. Such encodings, and any chosen result whose integer bit is clear, are replaced by a fixed default quiet NaN. That constant has the sign set, the exponent all ones and the significand 0xC000000000000000. The decision logic is combinational. A single registered stage, loaded when `in_valid` is high, presents the result one clock later.

Top module: `nan_pick_unit`

## Requirements
- R1: While reset is asserted and after its release with no accepted input, `out_valid`, `res_we`, `inv_req` and `inv_unmasked` are 0.
- R2: An input accepted with `in_valid`=1 at a rising edge appears on the outputs after that edge with `out_valid`=1. After an edge with `in_valid`=0, `out_valid`, `res_we`, `inv_req` and `inv_unmasked` are 0.
- R3: When both operands are NaN-tagged and supported, the operand with the numerically larger 64-bit significand is selected (sign and exponent travel with it), independent of which port it arrives on.
- R4: When both operands are NaN-tagged and supported and their significands are equal, the supplied default NaN (`dnan_*`) is selected, even when the operand signs differ.
- R5: When exactly one operand is NaN-tagged, that operand is the selected value.
- R6: A NaN is signalling when significand bit 62 is 0 and quiet when it is 1. If every NaN input is quiet, the selected value is written (`res_we`=1) with `inv_req`=0, whatever `inv_mask` holds.
- R7: If any NaN input is signalling and `inv_mask`=1, the selected value is written with significand bit 62 forced to 1, `inv_req`=1 and `inv_unmasked`=0.
- R8: If any NaN input is signalling and `inv_mask`=0, `res_we`=0, `inv_req`=1 and `inv_unmasked`=1.
- R9: A NaN-tagged operand with significand bit 63 equal to 0 is unsupported. It always gives `inv_req`=1. With `inv_mask`=1 the default quiet NaN is written. With `inv_mask`=0 nothing is written and `inv_unmasked`=1.
- R10: If the selected value has significand bit 63 equal to 0, the default quiet NaN is written in its place.
- R11: If neither operand is NaN-tagged, `res_we`, `inv_req` and `inv_unmasked` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| a_sign | input | 1 | Sign of operand A |
| a_exp | input | 15 | Biased exponent of operand A |
| a_sig | input | 64 | Significand of operand A, bit 63 is the integer bit |
| a_nan | input | 1 | Operand A is tagged NaN class |
| b_sign | input | 1 | Sign of operand B |
| b_exp | input | 15 | Biased exponent of operand B |
| b_sig | input | 64 | Significand of operand B |
| b_nan | input | 1 | Operand B is tagged NaN class |
| inv_mask | input | 1 | 1 = invalid-operation exception masked |
| dnan_sign | input | 1 | Sign of the supplied default NaN |
| dnan_exp | input | 15 | Exponent of the supplied default NaN |
| dnan_sig | input | 64 | Significand of the supplied default NaN |
| out_valid | output | 1 | Registered result is valid |
| res_sign | output | 1 | Result sign |
| res_exp | output | 15 | Result exponent |
| res_sig | output | 64 | Result significand |
| res_we | output | 1 | Destination write-enable |
| inv_req | output | 1 | Invalid-operation exception request |
| inv_unmasked | output | 1 | The invalid request is unmasked (no write happens) |

## Verification
Two of this block's duties can coincide in one cycle: the magnitude selection between two NaNs and the signalling-NaN handling. One case is a quiet NaN with the larger significand facing a signalling NaN. That result must be the quiet operand's value, written, while invalid is still raised. A second collision pairs an unsupported encoding with a valid NaN on the other port. There the unsupported rule must override the selection. Both collisions are provoked by dedicated vectors sent back to back with the other cases. The scoreboard judges them against hand-computed write-enable, exception flags and result fields.

// File: rtl/nanp_pkg.sv
package nanp_pkg;
  localparam int EXP_W     = 15;
  localparam int SIG_W     = 64;
  localparam int INT_BIT   = SIG_W - 1;
  localparam int QUIET_BIT = SIG_W - 2;
  localparam int XREAL_W   = 1 + EXP_W + SIG_W;

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] exp;
    logic [SIG_W-1:0] sig;
  } xreal_t;

  typedef enum logic [1:0] {
    PICK_A    = 2'd0,
    PICK_B    = 2'd1,
    PICK_DFLT = 2'd2,
    PICK_QNAN = 2'd3
  } pick_e;

  // Fixed quiet NaN used for unsupported encodings: negative, all-ones exponent,
  // integer and quiet bits set.
  function automatic xreal_t quiet_default();
    xreal_t q;
    q.sign = 1'b1;
    q.exp  = '1;
    q.sig  = '0;
    q.sig[INT_BIT]   = 1'b1;
    q.sig[QUIET_BIT] = 1'b1;
    return q;
  endfunction
endpackage

// File: rtl/nanp_sigcmp.sv
module nanp_sigcmp #(
  parameter int W = 64
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic         lhs_gt,
  output logic         both_eq
);
  always_comb begin
    lhs_gt  = (lhs > rhs);
    both_eq = (lhs == rhs);
  end
endmodule

// File: rtl/nanp_resolve.sv
module nanp_resolve
  import nanp_pkg::*;
(
  input  xreal_t op_a,
  input  logic   a_nan,
  input  xreal_t op_b,
  input  logic   b_nan,
  input  xreal_t dflt,
  input  logic   inv_mask,
  input  logic   a_gt_b,
  input  logic   a_eq_b,
  output xreal_t nxt_val,
  output logic   nxt_we,
  output logic   nxt_inv,
  output logic   nxt_unm
);
  logic   a_unsup, b_unsup, any_unsup, any_nan, snan;
  pick_e  pick;
  xreal_t picked, fixed;

  always_comb begin
    a_unsup   = a_nan & ~op_a.sig[INT_BIT];
    b_unsup   = b_nan & ~op_b.sig[INT_BIT];
    any_unsup = a_unsup | b_unsup;
    any_nan   = a_nan | b_nan;
  end

  // Which operand carries the NaN payload, and whether the input is signalling.
  always_comb begin
    pick = PICK_QNAN;
    snan = 1'b0;
    if (a_nan && b_nan) begin
      snan = ~(op_a.sig[QUIET_BIT] & op_b.sig[QUIET_BIT]);
      if (a_gt_b)      pick = PICK_A;
      else if (a_eq_b) pick = PICK_DFLT;
      else             pick = PICK_B;
    end else if (a_nan) begin
      snan = ~op_a.sig[QUIET_BIT];
      pick = PICK_A;
    end else if (b_nan) begin
      snan = ~op_b.sig[QUIET_BIT];
      pick = PICK_B;
    end
  end

  always_comb begin
    unique case (pick)
      PICK_A:    picked = op_a;
      PICK_B:    picked = op_b;
      PICK_DFLT: picked = dflt;
      default:   picked = quiet_default();
    endcase
    fixed = picked.sig[INT_BIT] ? picked : quiet_default();
  end

  always_comb begin
    nxt_val = fixed;
    nxt_we  = 1'b0;
    nxt_inv = 1'b0;
    nxt_unm = 1'b0;
    if (!any_nan) begin
      nxt_we = 1'b0;
    end else if (any_unsup) begin
      nxt_val = quiet_default();
      nxt_inv = 1'b1;
      nxt_we  = inv_mask;
      nxt_unm = ~inv_mask;
    end else if (snan && !inv_mask) begin
      nxt_inv = 1'b1;
      nxt_unm = 1'b1;
    end else begin
      nxt_we = 1'b1;
      nxt_inv = snan;
      nxt_val.sig[QUIET_BIT] = fixed.sig[QUIET_BIT] | snan;
    end
  end
endmodule

// File: rtl/nanp_stage.sv
module nanp_stage
  import nanp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load_en,
  input  xreal_t nxt_val,
  input  logic   nxt_we,
  input  logic   nxt_inv,
  input  logic   nxt_unm,
  output logic   q_valid,
  output xreal_t q_val,
  output logic   q_we,
  output logic   q_inv,
  output logic   q_unm
);
  xreal_t val_d;
  logic   vld_d, we_d, inv_d, unm_d;

  always_comb begin
    val_d = load_en ? nxt_val : q_val;
    vld_d = load_en;
    we_d  = load_en & nxt_we;
    inv_d = load_en & nxt_inv;
    unm_d = load_en & nxt_unm;
  end

  // Data path: no reset, loads under its enable.
  always_ff @(posedge clk) begin
    q_val <= val_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_we    <= 1'b0;
      q_inv   <= 1'b0;
      q_unm   <= 1'b0;
    end else begin
      q_valid <= vld_d;
      q_we    <= we_d;
      q_inv   <= inv_d;
      q_unm   <= unm_d;
    end
  end
endmodule

// File: rtl/nan_pick_unit.sv
module nan_pick_unit
  import nanp_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      a_sign,
  input  logic [nanp_pkg::EXP_W-1:0] a_exp,
  input  logic [nanp_pkg::SIG_W-1:0] a_sig,
  input  logic                      a_nan,
  input  logic                      b_sign,
  input  logic [nanp_pkg::EXP_W-1:0] b_exp,
  input  logic [nanp_pkg::SIG_W-1:0] b_sig,
  input  logic                      b_nan,
  input  logic                      inv_mask,
  input  logic                      dnan_sign,
  input  logic [nanp_pkg::EXP_W-1:0] dnan_exp,
  input  logic [nanp_pkg::SIG_W-1:0] dnan_sig,
  output logic                      out_valid,
  output logic                      res_sign,
  output logic [nanp_pkg::EXP_W-1:0] res_exp,
  output logic [nanp_pkg::SIG_W-1:0] res_sig,
  output logic                      res_we,
  output logic                      inv_req,
  output logic                      inv_unmasked
);
  xreal_t op_a, op_b, dflt, nxt_val, q_val;
  logic   a_gt_b, a_eq_b, nxt_we, nxt_inv, nxt_unm;

  always_comb begin
    op_a = '{sign: a_sign, exp: a_exp, sig: a_sig};
    op_b = '{sign: b_sign, exp: b_exp, sig: b_sig};
    dflt = '{sign: dnan_sign, exp: dnan_exp, sig: dnan_sig};
  end

  nanp_sigcmp #(.W(SIG_W)) u_cmp (
    .lhs     (a_sig),
    .rhs     (b_sig),
    .lhs_gt  (a_gt_b),
    .both_eq (a_eq_b)
  );

  nanp_resolve u_res (
    .op_a     (op_a),
    .a_nan    (a_nan),
    .op_b     (op_b),
    .b_nan    (b_nan),
    .dflt     (dflt),
    .inv_mask (inv_mask),
    .a_gt_b   (a_gt_b),
    .a_eq_b   (a_eq_b),
    .nxt_val  (nxt_val),
    .nxt_we   (nxt_we),
    .nxt_inv  (nxt_inv),
    .nxt_unm  (nxt_unm)
  );

  nanp_stage u_stg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (in_valid),
    .nxt_val (nxt_val),
    .nxt_we  (nxt_we),
    .nxt_inv (nxt_inv),
    .nxt_unm (nxt_unm),
    .q_valid (out_valid),
    .q_val   (q_val),
    .q_we    (res_we),
    .q_inv   (inv_req),
    .q_unm   (inv_unmasked)
  );

  always_comb begin
    res_sign = q_val.sign;
    res_exp  = q_val.exp;
    res_sig  = q_val.sig;
  end
endmodule

// File: rtl/nanp_checker.sv
module nanp_checker
  import nanp_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [SIG_W-1:0] a_sig,
  input logic             a_nan,
  input logic [SIG_W-1:0] b_sig,
  input logic             b_nan,
  input logic             out_valid,
  input logic [SIG_W-1:0] res_sig,
  input logic             res_we,
  input logic             inv_req,
  input logic             inv_unmasked
);
  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !res_we && !inv_req && !inv_unmasked));

  assert_quiet_in_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && a_nan && b_nan && a_sig[INT_BIT] && a_sig[QUIET_BIT]
      && b_sig[INT_BIT] && b_sig[QUIET_BIT]) |=> (res_we && !inv_req));

  assert_write_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we && inv_req) |-> res_sig[QUIET_BIT]);

  assert_unmasked_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_unmasked |-> (inv_req && !res_we));

  assert_int_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> res_sig[INT_BIT]);

  assert_no_nan_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !a_nan && !b_nan) |=> (!res_we && !inv_req));
endmodule

bind nan_pick_unit nanp_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .a_sig        (a_sig),
  .a_nan        (a_nan),
  .b_sig        (b_sig),
  .b_nan        (b_nan),
  .out_valid    (out_valid),
  .res_sig      (res_sig),
  .res_we       (res_we),
  .inv_req      (inv_req),
  .inv_unmasked (inv_unmasked)
);

// File: tb/nan_pick_unit_test.sv
`timescale 1ns/1ps
module nan_pick_unit_test;
  import nanp_pkg::*;

  logic clk, rst_n, in_valid;
  logic a_sign, b_sign, dnan_sign, a_nan, b_nan, inv_mask;
  logic [EXP_W-1:0] a_exp, b_exp, dnan_exp;
  logic [SIG_W-1:0] a_sig, b_sig, dnan_sig;
  logic out_valid, res_sign, res_we, inv_req, inv_unmasked;
  logic [EXP_W-1:0] res_exp;
  logic [SIG_W-1:0] res_sig;

  int total = 0;
  int bad   = 0;

  typedef struct packed {
    xreal_t val;
    logic   we;
    logic   inv;
    logic   unm;
  } exp_t;

  exp_t  sb_q[$];
  string tag_q[$];

  nan_pick_unit uut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic xreal_t mk(input logic s, input logic [EXP_W-1:0] e,
                                input logic [SIG_W-1:0] m);
    xreal_t x;
    x.sign = s; x.exp = e; x.sig = m;
    return x;
  endfunction

  localparam logic [EXP_W-1:0] EMAX = 15'h7FFF;
  xreal_t QN;
  xreal_t NONE;

  task automatic send(input xreal_t a, input logic an, input xreal_t b, input logic bn,
                      input logic m, input xreal_t d, input xreal_t e,
                      input logic ewe, input logic einv, input logic eunm,
                      input string tag);
    exp_t it;
    @(negedge clk);
    in_valid = 1'b1;
    a_sign = a.sign; a_exp = a.exp; a_sig = a.sig; a_nan = an;
    b_sign = b.sign; b_exp = b.exp; b_sig = b.sig; b_nan = bn;
    dnan_sign = d.sign; dnan_exp = d.exp; dnan_sig = d.sig;
    inv_mask = m;
    it.val = e; it.we = ewe; it.inv = einv; it.unm = eunm;
    sb_q.push_back(it);
    tag_q.push_back(tag);
  endtask

  // Monitor: compares each registered result against the queue head.
  always begin
    @(negedge clk);
    #1;
    if (rst_n && out_valid) begin
      total++;
      if (sb_q.size() == 0) begin
        bad++;
        $display("FAIL R2 unexpected out_valid: actual=1 expected=0");
      end else begin
        exp_t  it;
        string tg;
        logic  ok;
        it = sb_q.pop_front();
        tg = tag_q.pop_front();
        ok = (res_we === it.we) && (inv_req === it.inv) && (inv_unmasked === it.unm);
        if (it.we)
          ok = ok && (res_sign === it.val.sign) && (res_exp === it.val.exp)
                  && (res_sig === it.val.sig);
        if (!ok) begin
          bad++;
          $display("FAIL %s: actual we=%b inv=%b unm=%b val=%b/%h/%h expected we=%b inv=%b unm=%b val=%b/%h/%h",
                   tg, res_we, inv_req, inv_unmasked, res_sign, res_exp, res_sig,
                   it.we, it.inv, it.unm, it.val.sign, it.val.exp, it.val.sig);
        end
      end
    end
  end

  task automatic check_idle(input string tag);
    total++;
    if (out_valid !== 1'b0 || res_we !== 1'b0 || inv_req !== 1'b0 || inv_unmasked !== 1'b0) begin
      bad++;
      $display("FAIL %s: actual vld=%b we=%b inv=%b unm=%b expected all 0",
               tag, out_valid, res_we, inv_req, inv_unmasked);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    bad++; total++;
    $display("FAIL R2 watchdog expired: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    QN   = mk(1'b1, EMAX, 64'hC000_0000_0000_0000);
    NONE = mk(1'b0, EMAX, 64'hC000_0000_0000_0FFF);
    rst_n = 1'b0; in_valid = 1'b0;
    a_sign = 0; a_exp = '0; a_sig = '0; a_nan = 0;
    b_sign = 0; b_exp = '0; b_sig = '0; b_nan = 0;
    dnan_sign = 0; dnan_exp = '0; dnan_sig = '0; inv_mask = 1'b1;
    repeat (3) @(negedge clk);
    check_idle("R1 during reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1 check_idle("R1 after release");

    // R5/R6: only A is a quiet NaN, B is an ordinary 1.0
    send(mk(0, EMAX, 64'hC000_0000_0000_1234), 1, mk(0, 15'h3FFF, 64'h8000_0000_0000_0000), 0,
         1, NONE, mk(0, EMAX, 64'hC000_0000_0000_1234), 1, 0, 0, "R5 a-only quiet");
    // R5: only B is a quiet NaN
    send(mk(0, 15'h3FFF, 64'h8000_0000_0000_0000), 0, mk(1, EMAX, 64'hE000_0000_0000_0001), 1,
         1, NONE, mk(1, EMAX, 64'hE000_0000_0000_0001), 1, 0, 0, "R5 b-only quiet");
    // R3: both quiet, B larger
    send(mk(0, EMAX, 64'hC000_0000_0000_0005), 1, mk(1, EMAX, 64'hC000_0000_0000_0009), 1,
         1, NONE, mk(1, EMAX, 64'hC000_0000_0000_0009), 1, 0, 0, "R3 b larger");
    // R3: same pair swapped; larger still wins
    send(mk(1, EMAX, 64'hC000_0000_0000_0009), 1, mk(0, EMAX, 64'hC000_0000_0000_0005), 1,
         1, NONE, mk(1, EMAX, 64'hC000_0000_0000_0009), 1, 0, 0, "R3 a larger swapped");
    // R4: equal significands, differing signs -> supplied default
    send(mk(0, EMAX, 64'hC000_0000_0000_00AA), 1, mk(1, EMAX, 64'hC000_0000_0000_00AA), 1,
         1, mk(0, EMAX, 64'hC000_0000_0000_0777), mk(0, EMAX, 64'hC000_0000_0000_0777),
         1, 0, 0, "R4 equal picks default");
    // R7: signalling A alone, masked -> quieted and written
    send(mk(0, EMAX, 64'h8000_0000_0000_0042), 1, mk(0, 15'h3FFF, 64'h8000_0000_0000_0000), 0,
         1, NONE, mk(0, EMAX, 64'hC000_0000_0000_0042), 1, 1, 0, "R7 snan masked");
    // R7 + R3 collision: larger quiet A beats signalling B, invalid still raised
    send(mk(1, EMAX, 64'hC000_0000_0000_0001), 1, mk(0, EMAX, 64'h8000_0000_0000_00FF), 1,
         1, NONE, mk(1, EMAX, 64'hC000_0000_0000_0001), 1, 1, 0, "R7 quiet beats snan");
    // R8: signalling unmasked -> no write
    send(mk(0, EMAX, 64'h8000_0000_0000_0042), 1, mk(0, 15'h3FFF, 64'h8000_0000_0000_0000), 0,
         0, NONE, NONE, 0, 1, 1, "R8 snan unmasked");
    // R9: unsupported A with valid quiet B, masked
    send(mk(0, EMAX, 64'h4000_0000_0000_0000), 1, mk(0, EMAX, 64'hC000_0000_0000_0003), 1,
         1, NONE, QN, 1, 1, 0, "R9 unsupported masked");
    // R9: unsupported B, unmasked
    send(mk(0, EMAX, 64'hC000_0000_0000_0003), 1, mk(0, EMAX, 64'h0000_0000_0000_0001), 1,
         0, NONE, NONE, 0, 1, 1, "R9 unsupported unmasked");
    // R10: default NaN with clear integer bit is replaced
    send(mk(0, EMAX, 64'hC000_0000_0000_0010), 1, mk(0, EMAX, 64'hC000_0000_0000_0010), 1,
         1, mk(0, EMAX, 64'h4000_0000_0000_0001), QN, 1, 0, 0, "R10 default int bit clear");
    // R11: no NaN at all
    send(mk(0, 15'h3FFF, 64'h8000_0000_0000_0000), 0, mk(1, 15'h4000, 64'hC000_0000_0000_0000), 0,
         1, NONE, NONE, 0, 0, 0, "R11 no nan");
    // R6: quiet inputs with invalid unmasked still write silently
    send(mk(0, EMAX, 64'hC800_0000_0000_0000), 1, mk(1, EMAX, 64'hC000_0000_0000_0001), 1,
         0, NONE, mk(0, EMAX, 64'hC800_0000_0000_0000), 1, 0, 0, "R6 quiet unmasked");

    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    #1 check_idle("R2 idle after stream");
    total++;
    if (sb_q.size() != 0) begin
      bad++;
      $display("FAIL R2 pending results: actual=%0d expected=0", sb_q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule